// File: doc/BRIEF.md
# Sixteen-Nibble RAM with Open-Collector Complement Outputs

This block is a small static memory of sixteen 4-bit words. A single active-low enable gates every access. One select pin chooses the operation: low means write and high means read, so a select line left high defaults to read. A write is captured on the rising clock edge while the enable is low and the select is low.

The read port gives the complement of the stored word in open-collector form. Each output line is either pulled low or released. The port `oc_pull` shows this directly: bit i = 1 means line i is pulled low, and bit i = 0 means line i is released. A stored 1 has a complement of 0, so it pulls its line low. A stored 0 has a complement of 1, so it leaves its line released.

A built-in stage resolves the shared bus as a wired-AND with a pull-up. Other devices on the same wires join through `ext_pull`. A receiving inverter stage then restores the true polarity on `dout`.

Top module: `oc_nibble_ram`

## Requirements
- R1: The array holds 16 words of 4 bits. Addresses 0..15 are selected by `addr`, where `addr[3]` is the most significant bit, and each word is independently addressable.
- R2: While `mem_en_n` is high, no clock edge changes any stored word, whatever `wr_n`, `addr` and `din` are.
- R3: With `mem_en_n` low and `wr_n` low at a rising clock edge, `din` is stored at `addr`. The new value is readable from the following cycle on.
- R4: With `mem_en_n` low and `wr_n` high, `oc_pull[i]` = 1 (line pulled low) exactly when the complement of stored bit i is 0, i.e. when stored bit i is 1. Otherwise the line is released (`oc_pull[i]` = 0).
- R5: While `mem_en_n` is high, all four outputs are released (`oc_pull` = 0000).
- R6: While `mem_en_n` is low and `wr_n` is low, all four outputs are released.
- R7: `line_level[i]` is 0 if this device or any other device (`ext_pull[i]` = 1) pulls line i low, and 1 otherwise.
- R8: `dout` is the inverse of `line_level`. For a word holding 1011 read with no other device pulling, the lines read low, released, low, low on bits 3..0 (`line_level` = 0100) and `dout` = 1011.
- R9: Asserting `rst_n` low clears every word to 0000. Reset is asynchronous on assertion and released synchronously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes are taken on the rising edge |
| rst_n | input | 1 | Active-low reset, clears the array |
| addr | input | 4 | Word address, bit 3 most significant |
| din | input | 4 | Write data |
| mem_en_n | input | 1 | Active-low memory enable |
| wr_n | input | 1 | Operation select: 0 write, 1 read |
| ext_pull | input | 4 | Other devices on the shared lines: 1 = pulling that line low |
| oc_pull | output | 4 | This device's open-collector state: 1 = pulling low, 0 = released |
| line_level | output | 4 | Resolved wired-AND level of the shared lines |
| dout | output | 4 | Restored true data after the receiving inverters |

## Verification
All sixteen addresses are written with a permuted set of values (address XOR 1010), so every word differs from its neighbours. This exposes address aliasing or a swapped address bit. The values are read back as `oc_pull`, `line_level` and `dout`, and a fixed inversion or polarity slip shows up on every bit. With one word held at 1011, `ext_pull` is swept through all sixteen values to separate the wired-AND from a plain pass-through. Disabled write attempts and the write cycle itself are checked for released outputs and an unchanged array. Read-back after reset confirms the cleared state.

// File: rtl/oc_ram_pkg.sv
package oc_ram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } ram_op_e;

  // Enable is active low; select low writes, high reads.
  function automatic ram_op_e decode_op(input logic en_n, input logic wsel_n);
    if (en_n)        return OP_IDLE;
    else if (wsel_n) return OP_READ;
    else             return OP_WRITE;
  endfunction

endpackage

// File: rtl/oc_ram_array.sv
module oc_ram_array
  import oc_ram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ram_op_e           op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] mem_d [DEPTH];
  logic              word_we [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_comb begin
      word_we[g] = (op == OP_WRITE) && (addr == ADDR_W'(g));
      mem_d[g]   = mem_q[g];
      if (word_we[g]) mem_d[g] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[g] <= '0;
      else        mem_q[g] <= mem_d[g];
    end
  end

  assign rdata = mem_q[addr];

  // R3: a write is visible at its address on the next cycle
  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE) |=> (mem_q[$past(addr)] == $past(wdata)));

  // R2: an idle cycle leaves the addressed word untouched
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IDLE) |=> (mem_q[$past(addr)] == $past(rdata)));

endmodule

// File: rtl/oc_ram_driver.sv
module oc_ram_driver
  import oc_ram_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  ram_op_e           op,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] pull
);

  logic [DATA_W-1:0] cmpl;

  // Complement bit 0 sinks the line; complement bit 1 leaves it released.
  always_comb begin
    cmpl = ~rdata;
    pull = '0;
    if (op == OP_READ) pull = ~cmpl;
  end

endmodule

// File: rtl/oc_bus_resolve.sv
module oc_bus_resolve #(
  parameter int DATA_W = 4
) (
  input  logic [DATA_W-1:0] own_pull,
  input  logic [DATA_W-1:0] ext_pull,
  output logic [DATA_W-1:0] line,
  output logic [DATA_W-1:0] restored
);

  for (genvar b = 0; b < DATA_W; b++) begin : g_line
    // Pull-up wins unless some device sinks the line.
    assign line[b]     = (own_pull[b] || ext_pull[b]) ? 1'b0 : 1'b1;
    assign restored[b] = !line[b];
  end

endmodule

// File: rtl/oc_nibble_ram.sv
module oc_nibble_ram
  import oc_ram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              mem_en_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] ext_pull,
  output logic [DATA_W-1:0] oc_pull,
  output logic [DATA_W-1:0] line_level,
  output logic [DATA_W-1:0] dout
);

  ram_op_e           op;
  logic [DATA_W-1:0] rdata;

  assign op = decode_op(mem_en_n, wr_n);

  oc_ram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .addr  (addr),
    .wdata (din),
    .rdata (rdata)
  );

  oc_ram_driver #(.DATA_W(DATA_W)) u_driver (
    .op    (op),
    .rdata (rdata),
    .pull  (oc_pull)
  );

  oc_bus_resolve #(.DATA_W(DATA_W)) u_resolve (
    .own_pull (oc_pull),
    .ext_pull (ext_pull),
    .line     (line_level),
    .restored (dout)
  );

  // R5: disabled device releases every line
  p_release_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en_n |-> (oc_pull == '0));

  // R6: write cycle releases every line
  p_release_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_en_n && !wr_n) |-> (oc_pull == '0));

  // R8: alone on the bus, a read restores the stored word
  p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_en_n && wr_n && ext_pull == '0) |-> (dout == rdata));

  // R7: a line sunk by another device reads low
  p_wired_and_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_pull != '0) |-> ((line_level & ext_pull) == '0));

endmodule

// File: tb/oc_nibble_ram_bench.sv
module oc_nibble_ram_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] addr, din, ext_pull;
  logic       mem_en_n, wr_n;
  logic [3:0] oc_pull, line_level, dout;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  oc_nibble_ram u_oc_nibble_ram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .mem_en_n(mem_en_n), .wr_n(wr_n), .ext_pull(ext_pull),
    .oc_pull(oc_pull), .line_level(line_level), .dout(dout)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    addr = a; din = d; wr_n = 1'b0; mem_en_n = 1'b0;
    #1 chk("R6 write releases", oc_pull, 4'b0000);
    @(negedge clk);
    mem_en_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic do_read(input logic [3:0] a, input logic [3:0] exp, input string req);
    @(negedge clk);
    addr = a; wr_n = 1'b1; mem_en_n = 1'b0;
    #1;
    chk({req, " pull"}, oc_pull, exp);
    chk({req, " line"}, line_level, ~exp);
    chk({req, " dout"}, dout, exp);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; din = '0; mem_en_n = 1'b1; wr_n = 1'b1; ext_pull = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state is all zero, so every line is released
    for (int a = 0; a < 16; a++) do_read(4'(a), 4'b0000, "R9 reset");

    // R5: disabled outputs released
    @(negedge clk); mem_en_n = 1'b1; wr_n = 1'b1; addr = 4'd3;
    #1 chk("R5 disabled release", oc_pull, 4'b0000);

    // R1, R3: distinct pattern in every word
    for (int a = 0; a < 16; a++) do_write(4'(a), 4'(a) ^ 4'b1010);
    for (int a = 0; a < 16; a++) do_read(4'(a), 4'(a) ^ 4'b1010, "R1 R3 R4 readback");

    // R2: disabled write attempts change nothing
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      mem_en_n = 1'b1; wr_n = 1'b0; addr = 4'(a); din = ~(4'(a) ^ 4'b1010);
      #1 chk("R5 disabled during wr_n low", oc_pull, 4'b0000);
      @(negedge clk);
      wr_n = 1'b1;
    end
    for (int a = 0; a < 16; a++) do_read(4'(a), 4'(a) ^ 4'b1010, "R2 unchanged");

    // R8: worked example 1011
    do_write(4'd10, 4'b1011);
    do_read(4'd10, 4'b1011, "R8 example");
    chk("R4 example pull", oc_pull, 4'b1011);
    chk("R8 example line", line_level, 4'b0100);

    // R7: sweep other devices on the shared lines
    for (int e = 0; e < 16; e++) begin
      @(negedge clk);
      addr = 4'd10; mem_en_n = 1'b0; wr_n = 1'b1; ext_pull = 4'(e);
      #1;
      chk("R7 wired-AND line", line_level, ~(4'b1011 | 4'(e)));
      chk("R8 restored", dout, 4'b1011 | 4'(e));
    end
    for (int e = 0; e < 16; e++) begin
      @(negedge clk);
      mem_en_n = 1'b1; ext_pull = 4'(e);
      #1 chk("R7 disabled line", line_level, ~4'(e));
    end
    ext_pull = '0;

    // R9: mid-run reset clears contents
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 16; a++) do_read(4'(a), 4'b0000, "R9 reset clears");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule